// File: doc/BRIEF.md
# Packed-BCD Tick Counter Peripheral

This peripheral keeps a four-digit packed-decimal count that advances at a fixed rate of one or two steps per second. The rate comes from a prescaler that runs on the system clock. Software reaches it through a 16-byte window of four 32-bit registers on an APB-style bus:

| Offset | Register | Contents |
|---|---|---|
| 0x0 | control | run, interrupt enable, rate |
| 0x4 | status | step flag, start-value warning |
| 0x8 | start value | value loaded when the count starts |
| 0xC | count | current count, read-only |

Software writes a start value first. The block checks that value for decimal validity when it is written and keeps a sticky warning if it is not decimal. When the run bit is turned on, the count is loaded from the start value. If the warning is set, the count is loaded with zero instead.

Each step sets a flag. A level interrupt line is high while that flag and the interrupt enable are both set. Software clears the flag by writing the status register. The interrupt controller, decoding of the window base and any driver are outside the block.

Bus transfers use two phases, setup then access, with no wait states. Read data is captured in the setup cycle, so it is valid during the access cycle. A write takes effect on the clock edge that ends the access cycle.

Top module: `bcdcnt_periph`

## Requirements
- R1: After synchronous reset every register reads 0 and `irq` is low.
- R2: Only offsets 0x0, 0x4, 0x8 and 0xC are decoded. Any other offset reads 0, and a write to it changes no register. Bits of a register that the design does not use read 0.
- R3: The control register holds the run bit at bit 0, the interrupt enable at bit 1 and the rate bit at bit 2. It reads back what was last written to those bits.
- R4: While running, the count steps once every `CLK_HZ` clock cycles when the rate bit is 0, and once every `CLK_HZ/2` cycles when it is 1. The cycle counter starts again from zero when the run bit rises or the rate bit changes. The first step comes one full period after that write.
- R5: A write to the start-value register stores the 16-bit value and sets the warning (status bit 0) if any nibble is greater than 9. If every nibble is 9 or less, the write clears the warning.
- R6: A write that takes the run bit from 0 to 1 loads the count from the start value, or loads 0 if the warning is set. While the run bit is 0 the count holds its value.
- R7: Each step adds one in packed BCD, carrying decimally through all four digits. 9999 wraps to 0000, and each nibble of the count is always 9 or less.
- R8: A step sets the flag (status bit 1). A status write stores bit 1 of the written data in the flag, so writing 0 clears it. If a step and a status write fall in the same cycle, the step wins. Status writes never change the warning.
- R9: `irq` is high exactly when the flag and the interrupt enable are both 1.
- R10: Writes to the count register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock of frequency `CLK_HZ` |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Peripheral selected for a transfer |
| bus_en | input | 1 | Access phase of the transfer |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid in the access phase |
| irq | output | 1 | Level interrupt request |

## Verification
The bench uses a reduced `CLK_HZ` and exercises the step logic with several start values:
- 0x1234 and 0x9997 are valid start values. 0x9997 runs through the wrap from 9999 to 0000.
- 0x0999 carries through three digits at once.
- 0x12A4 and 0xF000 are invalid and must lead to a zero start.

Runs at both rates, a rate change in mid-run, a stopped period and a set of status writes spread across the step grid show the following:
- a wrong step period,
- a missed prescaler restart,
- a lost step-over-write priority,
- a count that moves while stopped.

Writes to the count register and to offsets outside the window, followed by read-back of every register, show whether those writes were ignored.

// File: rtl/bcdcnt_pkg.sv
package bcdcnt_pkg;

  localparam int REG_W = 32;

  // register offsets inside the 16-byte window
  localparam logic [3:0] OFS_CTRL  = 4'h0;
  localparam logic [3:0] OFS_STAT  = 4'h4;
  localparam logic [3:0] OFS_START = 4'h8;
  localparam logic [3:0] OFS_COUNT = 4'hC;

  // status field positions
  localparam int STAT_WARN_BIT = 0;
  localparam int STAT_FLAG_BIT = 1;

  // control register: bit0 run, bit1 irq enable, bit2 rate
  typedef struct packed {
    logic rate;
    logic ien;
    logic run;
  } ctrl_t;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_STAT,
    SEL_START,
    SEL_COUNT
  } reg_sel_e;

endpackage

// File: rtl/bcdcnt_decode.sv
module bcdcnt_decode
  import bcdcnt_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);

  logic in_window;

  generate
    if (ADDR_W > 4) begin : g_wide
      assign in_window = (addr[ADDR_W-1:4] == '0);
    end else begin : g_narrow
      assign in_window = 1'b1;
    end
  endgenerate

  always_comb begin
    sel = SEL_NONE;
    if (in_window) begin
      case (addr[3:0])
        OFS_CTRL:  sel = SEL_CTRL;
        OFS_STAT:  sel = SEL_STAT;
        OFS_START: sel = SEL_START;
        OFS_COUNT: sel = SEL_COUNT;
        default:   sel = SEL_NONE;
      endcase
    end
  end

endmodule

// File: rtl/bcdcnt_prescaler.sv
module bcdcnt_prescaler #(
  parameter int CLK_HZ = 50_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic fast,
  input  logic restart,
  output logic tick
);

  localparam int SLOW_LEN = CLK_HZ;
  localparam int FAST_LEN = CLK_HZ / 2;
  localparam int PW       = $clog2(SLOW_LEN);

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] last;
  logic          at_end;

  assign last   = fast ? PW'(FAST_LEN - 1) : PW'(SLOW_LEN - 1);
  assign at_end = (cnt_q == last);
  assign tick   = run && !restart && at_end;

  always_ff @(posedge clk) begin
    if (rst || !run || restart) begin
      cnt_q <= '0;
    end else if (at_end) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/bcdcnt_bcd_inc.sv
module bcdcnt_bcd_inc #(
  parameter int DIGITS = 4
) (
  input  logic [4*DIGITS-1:0] din,
  output logic [4*DIGITS-1:0] dout
);

  logic [DIGITS-1:0] carry;

  assign carry[0] = 1'b1;

  generate
    for (genvar g = 0; g < DIGITS; g++) begin : g_dig
      logic [3:0] d;
      assign d = din[4*g +: 4];
      assign dout[4*g +: 4] = !carry[g] ? d : ((d == 4'd9) ? 4'd0 : d + 4'd1);
      if (g < DIGITS - 1) begin : g_carry
        assign carry[g+1] = carry[g] && (d == 4'd9);
      end
    end
  endgenerate

endmodule

// File: rtl/bcdcnt_bcd_check.sv
module bcdcnt_bcd_check #(
  parameter int DIGITS = 4
) (
  input  logic [4*DIGITS-1:0] din,
  output logic                valid
);

  logic [DIGITS-1:0] bad;

  generate
    for (genvar g = 0; g < DIGITS; g++) begin : g_nib
      assign bad[g] = (din[4*g +: 4] > 4'd9);
    end
  endgenerate

  assign valid = ~|bad;

endmodule

// File: rtl/bcdcnt_periph.sv
module bcdcnt_periph
  import bcdcnt_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter int ADDR_W = 6,
  parameter int DIGITS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              irq
);

  localparam int CW = 4 * DIGITS;

  reg_sel_e        reg_sel;
  logic            wr_stb;
  logic            rd_setup;
  ctrl_t           ctrl_q, ctrl_d, wr_ctrl;
  logic            ifg_q, ifg_d;
  logic            warn_q, warn_d;
  logic [CW-1:0]   start_q, start_d;
  logic [CW-1:0]   count_q, count_d, count_inc;
  logic [REG_W-1:0] rdata_q, rd_val;
  logic            irq_q;
  logic            en_rise, rate_chg, restart, tick, start_ok;
  logic            unused_wdata;

  assign unused_wdata = ^bus_wdata[REG_W-1:CW];

  bcdcnt_decode #(.ADDR_W(ADDR_W)) i_decode (
    .addr (bus_addr),
    .sel  (reg_sel)
  );

  assign wr_stb   = bus_sel && bus_en && bus_wr;
  assign rd_setup = bus_sel && !bus_en && !bus_wr;
  assign wr_ctrl  = ctrl_t'(bus_wdata[2:0]);

  assign en_rise  = wr_stb && (reg_sel == SEL_CTRL) && wr_ctrl.run && !ctrl_q.run;
  assign rate_chg = wr_stb && (reg_sel == SEL_CTRL) && (wr_ctrl.rate != ctrl_q.rate);
  assign restart  = en_rise || rate_chg;

  bcdcnt_prescaler #(.CLK_HZ(CLK_HZ)) i_prescaler (
    .clk     (clk),
    .rst     (rst),
    .run     (ctrl_q.run),
    .fast    (ctrl_q.rate),
    .restart (restart),
    .tick    (tick)
  );

  bcdcnt_bcd_inc #(.DIGITS(DIGITS)) i_inc (
    .din  (count_q),
    .dout (count_inc)
  );

  bcdcnt_bcd_check #(.DIGITS(DIGITS)) i_check (
    .din   (bus_wdata[CW-1:0]),
    .valid (start_ok)
  );

  always_comb begin
    ctrl_d  = ctrl_q;
    ifg_d   = ifg_q;
    warn_d  = warn_q;
    start_d = start_q;
    count_d = count_q;

    if (wr_stb && reg_sel == SEL_CTRL) begin
      ctrl_d = wr_ctrl;
    end

    if (wr_stb && reg_sel == SEL_START) begin
      start_d = bus_wdata[CW-1:0];
      warn_d  = !start_ok;
    end

    if (tick) begin
      ifg_d = 1'b1;
    end else if (wr_stb && reg_sel == SEL_STAT) begin
      ifg_d = bus_wdata[STAT_FLAG_BIT];
    end

    if (en_rise) begin
      count_d = warn_q ? '0 : start_q;
    end else if (tick) begin
      count_d = count_inc;
    end
  end

  always_comb begin
    rd_val = '0;
    case (reg_sel)
      SEL_CTRL:  rd_val = REG_W'(ctrl_q);
      SEL_STAT:  begin
        rd_val[STAT_FLAG_BIT] = ifg_q;
        rd_val[STAT_WARN_BIT] = warn_q;
      end
      SEL_START: rd_val = REG_W'(start_q);
      SEL_COUNT: rd_val = REG_W'(count_q);
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      ifg_q   <= 1'b0;
      warn_q  <= 1'b0;
      start_q <= '0;
      count_q <= '0;
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      ifg_q   <= ifg_d;
      warn_q  <= warn_d;
      start_q <= start_d;
      count_q <= count_d;
      irq_q   <= ctrl_d.ien && ifg_d;
      if (rd_setup) begin
        rdata_q <= rd_val;
      end
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;

endmodule

// File: rtl/bcdcnt_periph_chk.sv
module bcdcnt_periph_chk
  import bcdcnt_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_stb,
  input reg_sel_e            reg_sel,
  input logic                en_rise,
  input logic                tick,
  input logic                run,
  input logic                ien,
  input logic                ifg_q,
  input logic                warn_q,
  input logic [4*DIGITS-1:0] count_q,
  input logic                irq
);

  function automatic logic all_decimal(input logic [4*DIGITS-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < DIGITS; i++) begin
      if (v[4*i +: 4] > 4'd9) ok = 1'b0;
    end
    return ok;
  endfunction

  // R7
  count_decimal_chk: assert property (@(posedge clk) disable iff (rst)
    all_decimal(count_q));

  // R9
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (ien && ifg_q));

  // R8
  step_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> ifg_q);

  // R8
  stat_keeps_warn_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && reg_sel == SEL_STAT) |=> $stable(warn_q));

  // R10
  count_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && reg_sel == SEL_COUNT && !tick) |=> $stable(count_q));

  // R6
  idle_no_step_chk: assert property (@(posedge clk) disable iff (rst)
    !run |-> !tick);

  // R6
  warn_zero_start_chk: assert property (@(posedge clk) disable iff (rst)
    (en_rise && warn_q) |=> (count_q == '0));

endmodule

bind bcdcnt_periph bcdcnt_periph_chk #(.DIGITS(DIGITS)) i_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_stb  (wr_stb),
  .reg_sel (reg_sel),
  .en_rise (en_rise),
  .tick    (tick),
  .run     (ctrl_q.run),
  .ien     (ctrl_q.ien),
  .ifg_q   (ifg_q),
  .warn_q  (warn_q),
  .count_q (count_q),
  .irq     (irq)
);

// File: tb/test_bcdcnt_periph.sv
module test_bcdcnt_periph;

  localparam int CLK_HZ = 40;
  localparam int ADDR_W = 6;
  localparam int DIGITS = 4;
  localparam int WD_CYC = 150000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_sel = 1'b0;
  logic              bus_en = 1'b0;
  logic              bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10ns clk = ~clk;

  bcdcnt_periph #(.CLK_HZ(CLK_HZ), .ADDR_W(ADDR_W), .DIGITS(DIGITS)) i_bcdcnt_periph (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_en    (bus_en),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  // ---------------- reference model ----------------
  logic        m_run, m_ien, m_fast, m_ifg, m_warn, m_irq;
  logic [15:0] m_start;
  int          m_count, m_presc;
  logic [31:0] m_rdata;
  bit          w_hit, w_rise, w_clr, w_tick;
  int          w_addr, w_len;

  function automatic logic [15:0] to_bcd(input int v);
    return {4'(v / 1000), 4'((v / 100) % 10), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  function automatic int from_bcd(input logic [15:0] b);
    return int'(b[15:12]) * 1000 + int'(b[11:8]) * 100 + int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic bit is_decimal(input logic [15:0] b);
    return (b[15:12] <= 9) && (b[11:8] <= 9) && (b[7:4] <= 9) && (b[3:0] <= 9);
  endfunction

  function automatic logic [31:0] mdl_read(input int a);
    case (a)
      0:  return {29'd0, m_fast, m_ien, m_run};
      4:  return {30'd0, m_ifg, m_warn};
      8:  return {16'd0, m_start};
      12: return {16'd0, to_bcd(m_count)};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_run = 0; m_ien = 0; m_fast = 0; m_ifg = 0; m_warn = 0; m_irq = 0;
      m_start = 0; m_count = 0; m_presc = 0; m_rdata = 0;
    end else begin
      w_addr = int'(bus_addr);
      w_hit  = bus_sel && bus_en && bus_wr;
      w_len  = m_fast ? CLK_HZ / 2 : CLK_HZ;
      w_rise = w_hit && w_addr == 0 && bus_wdata[0] && !m_run;
      w_clr  = w_rise || (w_hit && w_addr == 0 && bus_wdata[2] != m_fast);
      w_tick = m_run && !w_clr && (m_presc == w_len - 1);
      if (bus_sel && !bus_en && !bus_wr) m_rdata = mdl_read(w_addr);
      if (!m_run || w_clr || m_presc == w_len - 1) m_presc = 0;
      else m_presc = m_presc + 1;
      if (w_rise) m_count = m_warn ? 0 : from_bcd(m_start);
      else if (w_tick) m_count = (m_count + 1) % 10000;
      if (w_tick) m_ifg = 1;
      else if (w_hit && w_addr == 4) m_ifg = bus_wdata[1];
      if (w_hit && w_addr == 8) begin
        m_start = bus_wdata[15:0];
        m_warn  = !is_decimal(bus_wdata[15:0]);
      end
      if (w_hit && w_addr == 0) begin
        m_run = bus_wdata[0]; m_ien = bus_wdata[1]; m_fast = bus_wdata[2];
      end
      m_irq = m_ien && m_ifg;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // R9: interrupt line compared on every clock
  always @(negedge clk) begin
    if (!rst && !done) chk("R9 irq", {31'd0, irq}, {31'd0, m_irq});
  end

  task automatic bus_write(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_en = 0; bus_wr = 1; bus_addr = ADDR_W'(a); bus_wdata = d;
    @(negedge clk);
    bus_en = 1;
    @(negedge clk);
    bus_sel = 0; bus_en = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input int a, input string tag);
    @(negedge clk);
    bus_sel = 1; bus_en = 0; bus_wr = 0; bus_addr = ADDR_W'(a);
    @(negedge clk);
    bus_en = 1;
    chk(tag, bus_rdata, m_rdata);
    @(negedge clk);
    bus_sel = 0; bus_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    idle(5);
    rst = 0;
    // R1 reset state
    bus_read(0, "R1 ctrl"); bus_read(4, "R1 stat");
    bus_read(8, "R1 start"); bus_read(12, "R1 count");
    chk("R1 irq", {31'd0, irq}, 32'd0);
    // R2 outside window
    bus_write(8, 32'hFFFF_1234);
    bus_read(16, "R2 off 0x10"); bus_read(60, "R2 off 0x3C");
    bus_write(32, 32'hFFFF_FFFF);
    bus_read(0, "R2 ctrl after stray write");
    bus_read(4, "R2 stat after stray write");
    bus_read(8, "R2 start upper bits zero");
    // R5 start value checks
    bus_read(4, "R5 valid start clears warn");
    bus_write(8, 32'h0000_12A4); bus_read(4, "R5 nibble A sets warn");
    bus_write(8, 32'h0000_F000); bus_read(4, "R5 top nibble F sets warn");
    // R8 status write keeps warn
    bus_write(4, 32'h0000_0000); bus_read(4, "R8 warn survives status write");
    // R6 zero start, R4 slow rate
    bus_write(0, 32'h1); bus_read(12, "R6 zero start after warn");
    idle(80); bus_read(12, "R4 slow steps");
    bus_read(0, "R3 ctrl run only");
    // R6 stop holds count
    bus_write(0, 32'h0); bus_read(12, "R6 stopped");
    idle(60); bus_read(12, "R6 still stopped");
    // R7 wrap with fast rate and irq
    bus_write(8, 32'h0000_9997); bus_read(4, "R5 warn cleared");
    bus_write(0, 32'h7); bus_read(0, "R3 ctrl all bits");
    bus_read(12, "R6 load start value");
    idle(30); bus_read(12, "R4 fast step");
    idle(50); bus_read(12, "R7 wrap 9999 to 0000");
    bus_read(4, "R8 flag set by step");
    // R8 clear flag and re-set
    bus_write(4, 32'h0); bus_read(4, "R8 flag cleared");
    idle(22); bus_read(4, "R8 flag set again");
    // R8 priority sweep: status writes against step grid
    for (int i = 0; i < 25; i++) bus_write(4, 32'h0);
    bus_read(4, "R8 step wins over clear");
    // R10 count write ignored
    bus_write(12, 32'h0000_5555); bus_read(12, "R10 count not written");
    // R4 rate change restarts prescaler
    bus_write(0, 32'h3); idle(45); bus_read(12, "R4 after rate change");
    // R9 irq enable off
    bus_write(0, 32'h1); bus_read(0, "R3 ien cleared");
    idle(5);
    // R7 multi-digit carry
    bus_write(0, 32'h0); bus_write(8, 32'h0000_0999);
    bus_write(0, 32'h5); idle(22); bus_read(12, "R7 0999 carries to 1000");
    bus_write(4, 32'h2); bus_read(4, "R8 write one sets flag");
    idle(3);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule